// File: doc/BRIEF.md
# Two-Channel Serial Port Interrupt and Status Unit

This block sits on a CPU register bus and holds the status and interrupt logic for a two-channel serial port. Channel A is the console and channel B is the auxiliary port. Each channel has a one-entry receive buffer. A byte stream feeds the buffer through a valid/ready handshake. The CPU reads the buffer through the channel's holding register. A write to that same holding register hands one byte to the transmit side as a single-cycle pulse. The block does not include baud generation, line framing, the counter/timer or the output port.

A shared 8-bit register records interrupt causes. A write to its address loads the enable mask. A read from its address returns the recorded causes. A periodic tick input stands in for a real transmit shifter: every second tick marks both transmitters ready. The interrupt output is a level held by its own small state machine. Once raised, it stays asserted until the CPU reads channel A's status register or the block is reset. Clearing individual cause bits does not drop it.

The design has four state machines:
- Receive slot, one per channel: states `RX_EMPTY` and `RX_FULL`. It moves EMPTY→FULL when a byte is accepted, and FULL→EMPTY when the holding register is read.
- Tick pacer: states `TICK_EVEN` and `TICK_ODD`. Each tick toggles the state. The tick that arrives while in ODD fires the pacer.
- Transmitter control, one per channel: states `TX_ON` and `TX_OFF`. A command write with the disable bit moves ON→OFF. A command write with the enable bit moves OFF→ON.
- Interrupt line: states `IRQ_IDLE` and `IRQ_ACTIVE`. A raising event moves IDLE→ACTIVE. A channel A status read moves ACTIVE→IDLE.

Top module: `duart_irq_unit`

## Requirements
- R1: After reset:
  - `irq` is 0.
  - Both `rx_*_ready` are 1.
  - No transmit, flush or disable output is asserted.
  - The cause register and the mask both read as 0.
- R2: A read returns its data on `bus_rdata` one cycle after `bus_rd`. `bus_rdata` is 0 in any cycle that follows no read. Reading status (A at 0x0C, B at 0x4C) returns:
  - 0x04 (transmitter ready, always set) when the receive buffer is empty.
  - 0x05 when the receive buffer holds a byte.
- R3: A channel accepts a byte when `rx_*_valid` and `rx_*_ready` are both high. `rx_*_ready` then stays low until the holding register is read. A byte offered while the buffer is full is not taken.
- R4: The cause/mask address is 0x2C. A write there loads the mask, using bits 0x01, 0x02, 0x10 and 0x20. A read there returns the causes:
  - 0x01: transmitter A ready.
  - 0x02: receive A.
  - 0x10: transmitter B ready.
  - 0x20: receive B.
- R5: Accepting a byte sets that channel's receive cause and raises `irq` only if the matching mask bit is set. With the bit clear, the causes and `irq` are unchanged.
- R6: Reading a holding register (A 0x1C, B 0x5C) does three things:
  - It returns the buffered byte.
  - It clears that channel's receive cause.
  - It frees the buffer.
  
  Reading an empty holding register returns 0x00.
- R7: Writing a holding register does two things:
  - It pulses that channel's `tx_*_valid` for one cycle, with the byte on `tx_*_data`.
  - It clears only that channel's transmitter-ready cause.
- R8: On every second `tick`, if mask bit 0x01 or 0x10 is set, both transmitter-ready causes are set and `irq` is raised. Odd ticks have no effect. The tick count restarts after every second tick, whatever the mask holds.
- R9: `irq` is a level. Only a read of channel A's status register, or reset, clears it. Reading channel B's status register does not clear it, and neither does clearing cause bits. If a raising event and a channel A status read fall in the same cycle, `irq` stays asserted.
- R10: A command write (A 0x14, B 0x54) with bit 3 (0x08) set does two things:
  - It sets that channel's `tx_*_off`.
  - It pulses `flush_*` for one cycle.
  
  A command write with bit 2 (0x04) set and bit 3 clear clears `tx_*_off`.
- R11: Other offsets return 0 when read, and writes to them change nothing. This includes the mode registers at 0x04 and 0x44.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_a_valid | input | 1 | Channel A receive byte offered |
| rx_a_data | input | DATA_W | Channel A receive byte |
| rx_a_ready | output | 1 | Channel A buffer empty |
| rx_b_valid | input | 1 | Channel B receive byte offered |
| rx_b_data | input | DATA_W | Channel B receive byte |
| rx_b_ready | output | 1 | Channel B buffer empty |
| tx_a_valid | output | 1 | Channel A transmit byte pulse |
| tx_a_data | output | DATA_W | Channel A transmit byte |
| tx_b_valid | output | 1 | Channel B transmit byte pulse |
| tx_b_data | output | DATA_W | Channel B transmit byte |
| tx_a_off | output | 1 | Channel A transmitter disabled |
| tx_b_off | output | 1 | Channel B transmitter disabled |
| flush_a | output | 1 | Channel A flush request pulse |
| flush_b | output | 1 | Channel B flush request pulse |
| tick | input | 1 | Periodic pacing tick |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a raising event in the same cycle as a channel A status read. The bench sets this up by counting ticks from reset, so it knows which tick will fire. It then asserts that firing tick in the same cycle as the status read strobe. A second case is also easy to miss: `irq` staying high after every cause bit has been cleared. The bench drains both receive buffers and reads channel B status first, and only then reads channel A status, which shows that the level and the cause register are tracked separately.

// File: rtl/duart_pkg.sv
package duart_pkg;
    // number of serial channels served by the unit
    localparam int unsigned NCH        = 2;
    // register offsets of channel 0; channel n adds n * CH_STRIDE
    localparam int unsigned CH_STRIDE  = 'h40;
    localparam int unsigned OFS_MODE   = 'h04;
    localparam int unsigned OFS_STAT   = 'h0C;
    localparam int unsigned OFS_CMD    = 'h14;
    localparam int unsigned OFS_HOLD   = 'h1C;
    localparam int unsigned OFS_CAUSE  = 'h2C;
    // cause/mask layout: each channel owns a nibble
    localparam int unsigned CAUSE_TX   = 0;
    localparam int unsigned CAUSE_RX   = 1;
    localparam int unsigned CAUSE_STEP = 4;
    // status byte layout
    localparam int unsigned STAT_RX_BIT = 0;
    localparam int unsigned STAT_TX_BIT = 2;
    // command byte layout
    localparam int unsigned CMD_ON_BIT  = 2;
    localparam int unsigned CMD_OFF_BIT = 3;

    typedef enum logic { RX_EMPTY, RX_FULL }     rx_state_e;
    typedef enum logic { TICK_EVEN, TICK_ODD }   tick_state_e;
    typedef enum logic { TX_ON, TX_OFF }         tx_state_e;
    typedef enum logic { IRQ_IDLE, IRQ_ACTIVE }  irq_state_e;
endpackage

// File: rtl/duart_rx_slot.sv
module duart_rx_slot
    import duart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              avail,
    output logic              arrive,
    output logic [DATA_W-1:0] data_o
);
    rx_state_e          state_q, state_d;
    logic [DATA_W-1:0]  byte_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (in_valid) state_d = RX_FULL;
            RX_FULL:  if (take)     state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_EMPTY && in_valid)
                byte_q <= in_data;
        end
    end

    always_comb begin
        in_ready = (state_q == RX_EMPTY);
        avail    = (state_q == RX_FULL);
        arrive   = (state_q == RX_EMPTY) && in_valid;
        data_o   = avail ? byte_q : '0;
    end
endmodule

// File: rtl/duart_tick_fsm.sv
module duart_tick_fsm
    import duart_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);
    tick_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TICK_EVEN: if (tick) state_d = TICK_ODD;
            TICK_ODD:  if (tick) state_d = TICK_EVEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TICK_EVEN;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = (state_q == TICK_ODD) && tick;
    end
endmodule

// File: rtl/duart_tx_port.sv
module duart_tx_port
    import duart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_wr,
    input  logic              cmd_wr,
    input  logic              cmd_off,
    input  logic              cmd_on,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_off,
    output logic              flush
);
    tx_state_e          state_q, state_d;
    logic               valid_q, flush_q;
    logic [DATA_W-1:0]  data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_ON:  if (cmd_wr && cmd_off)                 state_d = TX_OFF;
            TX_OFF: if (cmd_wr && cmd_on && !cmd_off)      state_d = TX_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_ON;
            valid_q <= 1'b0;
            data_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= hold_wr;
            flush_q <= cmd_wr && cmd_off;
            if (hold_wr) data_q <= wdata;
        end
    end

    always_comb begin
        tx_valid = valid_q;
        tx_data  = data_q;
        tx_off   = (state_q == TX_OFF);
        flush    = flush_q;
    end
endmodule

// File: rtl/duart_irq_ctrl.sv
module duart_irq_ctrl
    import duart_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    // a raising event beats a clearing read in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (set_i)                state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (clr_i && !set_i)      state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/duart_irq_unit.sv
module duart_irq_unit
    import duart_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_a_valid,
    input  logic [DATA_W-1:0] rx_a_data,
    output logic              rx_a_ready,
    input  logic              rx_b_valid,
    input  logic [DATA_W-1:0] rx_b_data,
    output logic              rx_b_ready,
    output logic              tx_a_valid,
    output logic [DATA_W-1:0] tx_a_data,
    output logic              tx_b_valid,
    output logic [DATA_W-1:0] tx_b_data,
    output logic              tx_a_off,
    output logic              tx_b_off,
    output logic              flush_a,
    output logic              flush_b,
    input  logic              tick,
    output logic              irq
);
    localparam int CAUSE_BITS = NCH * CAUSE_STEP;

    // per-channel views of the port list
    logic [NCH-1:0]    rx_valid, rx_ready, avail, arrive;
    logic [DATA_W-1:0] rx_data [NCH];
    logic [DATA_W-1:0] slot_data [NCH];
    logic [NCH-1:0]    tx_valid_v, tx_off_v, flush_v;
    logic [DATA_W-1:0] tx_data_v [NCH];

    // decode
    logic [NCH-1:0] sel_stat, sel_hold, sel_cmd;
    logic [NCH-1:0] stat_rd, hold_rd, hold_wr, cmd_wr;
    logic           sel_cause, mask_wr;

    // causes and mask
    logic [NCH-1:0] cause_tx_q, cause_rx_q, mask_tx_q, mask_rx_q;
    logic [NCH-1:0] rx_set;
    logic           fire, tx_fire, irq_set;
    logic [DATA_W-1:0] cause_byte, rd_mux, rdata_q;

    assign rx_valid   = {rx_b_valid, rx_a_valid};
    assign rx_data[0] = rx_a_data;
    assign rx_data[1] = rx_b_data;
    assign rx_a_ready = rx_ready[0];
    assign rx_b_ready = rx_ready[1];
    assign tx_a_valid = tx_valid_v[0];
    assign tx_b_valid = tx_valid_v[1];
    assign tx_a_data  = tx_data_v[0];
    assign tx_b_data  = tx_data_v[1];
    assign tx_a_off   = tx_off_v[0];
    assign tx_b_off   = tx_off_v[1];
    assign flush_a    = flush_v[0];
    assign flush_b    = flush_v[1];

    assign sel_cause = (bus_addr == ADDR_W'(OFS_CAUSE));
    assign mask_wr   = bus_wr && sel_cause;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign sel_stat[ch] = (bus_addr == ADDR_W'(OFS_STAT + ch * CH_STRIDE));
        assign sel_hold[ch] = (bus_addr == ADDR_W'(OFS_HOLD + ch * CH_STRIDE));
        assign sel_cmd[ch]  = (bus_addr == ADDR_W'(OFS_CMD  + ch * CH_STRIDE));
        assign stat_rd[ch]  = bus_rd && sel_stat[ch];
        assign hold_rd[ch]  = bus_rd && sel_hold[ch];
        assign hold_wr[ch]  = bus_wr && sel_hold[ch];
        assign cmd_wr[ch]   = bus_wr && sel_cmd[ch];
        assign rx_set[ch]   = arrive[ch] && mask_rx_q[ch];

        duart_rx_slot #(.DATA_W(DATA_W)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (rx_valid[ch]),
            .in_data  (rx_data[ch]),
            .in_ready (rx_ready[ch]),
            .take     (hold_rd[ch]),
            .avail    (avail[ch]),
            .arrive   (arrive[ch]),
            .data_o   (slot_data[ch])
        );

        duart_tx_port #(.DATA_W(DATA_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_wr  (hold_wr[ch]),
            .cmd_wr   (cmd_wr[ch]),
            .cmd_off  (bus_wdata[CMD_OFF_BIT]),
            .cmd_on   (bus_wdata[CMD_ON_BIT]),
            .wdata    (bus_wdata),
            .tx_valid (tx_valid_v[ch]),
            .tx_data  (tx_data_v[ch]),
            .tx_off   (tx_off_v[ch]),
            .flush    (flush_v[ch])
        );
    end

    duart_tick_fsm u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (fire)
    );

    // any enabled transmit cause arms both transmit causes
    assign tx_fire = fire && (|mask_tx_q);
    assign irq_set = tx_fire || (|rx_set);

    duart_irq_ctrl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (stat_rd[0]),
        .irq_o (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_tx_q <= '0;
            cause_rx_q <= '0;
            mask_tx_q  <= '0;
            mask_rx_q  <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (rx_set[ch])       cause_rx_q[ch] <= 1'b1;
                else if (hold_rd[ch]) cause_rx_q[ch] <= 1'b0;
                if (tx_fire)          cause_tx_q[ch] <= 1'b1;
                else if (hold_wr[ch]) cause_tx_q[ch] <= 1'b0;
                if (mask_wr) begin
                    mask_tx_q[ch] <= bus_wdata[ch * CAUSE_STEP + CAUSE_TX];
                    mask_rx_q[ch] <= bus_wdata[ch * CAUSE_STEP + CAUSE_RX];
                end
            end
        end
    end

    always_comb begin
        cause_byte = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            cause_byte[ch * CAUSE_STEP + CAUSE_TX] = cause_tx_q[ch];
            cause_byte[ch * CAUSE_STEP + CAUSE_RX] = cause_rx_q[ch];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_cause) rd_mux = cause_byte;
        for (int ch = 0; ch < NCH; ch++) begin
            if (sel_stat[ch]) begin
                rd_mux              = '0;
                rd_mux[STAT_TX_BIT] = 1'b1;
                rd_mux[STAT_RX_BIT] = avail[ch];
            end
            if (sel_hold[ch]) rd_mux = slot_data[ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    initial begin
        if (DATA_W < CAUSE_BITS) $error("DATA_W too narrow for cause layout");
    end
endmodule

// File: rtl/duart_irq_unit_sva.sv
module duart_irq_unit_sva
    import duart_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_a_valid,
    input logic              rx_a_ready,
    input logic              rx_b_valid,
    input logic              tx_a_valid,
    input logic [DATA_W-1:0] tx_a_data,
    input logic              tx_a_off,
    input logic              flush_a,
    input logic              tick,
    input logic              irq
);
    logic rd_stat_a;
    assign rd_stat_a = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_stat_txrdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_a |=> bus_rdata[STAT_TX_BIT]);

    assert_rx_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_a_valid && rx_a_ready) |=> !rx_a_ready);

    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_HOLD))
        |=> (tx_a_valid && tx_a_data == $past(bus_wdata)));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stat_a) |=> irq);

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_a && !tick && !rx_a_valid && !rx_b_valid) |=> !irq);

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CMD) && bus_wdata[CMD_OFF_BIT])
        |=> (flush_a && tx_a_off));
endmodule

bind duart_irq_unit duart_irq_unit_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_a_valid (rx_a_valid),
    .rx_a_ready (rx_a_ready),
    .rx_b_valid (rx_b_valid),
    .tx_a_valid (tx_a_valid),
    .tx_a_data  (tx_a_data),
    .tx_a_off   (tx_a_off),
    .flush_a    (flush_a),
    .tick       (tick),
    .irq        (irq)
);

// File: tb/duart_irq_unit_tb_top.sv
module duart_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_a_valid = 1'b0;
    logic [7:0] rx_a_data = '0;
    logic       rx_a_ready;
    logic       rx_b_valid = 1'b0;
    logic [7:0] rx_b_data = '0;
    logic       rx_b_ready;
    logic       tx_a_valid, tx_b_valid, tx_a_off, tx_b_off, flush_a, flush_b;
    logic [7:0] tx_a_data, tx_b_data;
    logic       tick = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    duart_irq_unit #(.ADDR_W(8), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_a_valid(rx_a_valid), .rx_a_data(rx_a_data), .rx_a_ready(rx_a_ready),
        .rx_b_valid(rx_b_valid), .rx_b_data(rx_b_data), .rx_b_ready(rx_b_ready),
        .tx_a_valid(tx_a_valid), .tx_a_data(tx_a_data),
        .tx_b_valid(tx_b_valid), .tx_b_data(tx_b_data),
        .tx_a_off(tx_a_off), .tx_b_off(tx_b_off),
        .flush_a(flush_a), .flush_b(flush_b), .tick(tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic push_rx(input int ch, input logic [7:0] b);
        @(negedge clk);
        if (ch == 0) begin rx_a_valid = 1'b1; rx_a_data = b; end
        else         begin rx_b_valid = 1'b1; rx_b_data = b; end
        @(posedge clk); #1;
        rx_a_valid = 1'b0; rx_b_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", irq, 0);
        chk("R1 rx_a_ready", rx_a_ready, 1);
        chk("R1 rx_b_ready", rx_b_ready, 1);
        chk("R1 tx/flush/off", {tx_a_valid, tx_b_valid, flush_a, flush_b, tx_a_off, tx_b_off}, 0);
        chk("R2 idle rdata", bus_rdata, 0);
        do_read(8'h2C, d); chk("R1 causes", d, 8'h00);
        do_read(8'h0C, d); chk("R2 status A empty", d, 8'h04);
        do_read(8'h4C, d); chk("R2 status B empty", d, 8'h04);
    endtask

    task automatic t_rx_masked();
        logic [7:0] d;
        push_rx(0, 8'h5A);
        chk("R3 ready drops", rx_a_ready, 0);
        chk("R5 masked irq", irq, 0);
        push_rx(0, 8'h77);
        do_read(8'h2C, d); chk("R5 masked cause", d, 8'h00);
        do_read(8'h0C, d); chk("R2 status A full", d, 8'h05);
        do_read(8'h1C, d); chk("R3 R6 first byte kept", d, 8'h5A);
        chk("R6 slot freed", rx_a_ready, 1);
        do_read(8'h1C, d); chk("R6 empty hold", d, 8'h00);
    endtask

    task automatic t_rx_enabled();
        logic [7:0] d;
        do_write(8'h2C, 8'h22);
        push_rx(0, 8'h11);
        chk("R5 irq raised", irq, 1);
        push_rx(1, 8'hC3);
        do_read(8'h2C, d); chk("R4 R5 causes", d, 8'h22);
        do_read(8'h4C, d); chk("R2 status B full", d, 8'h05);
        chk("R9 status B keeps irq", irq, 1);
        do_read(8'h5C, d); chk("R6 hold B", d, 8'hC3);
        do_read(8'h2C, d); chk("R6 cause B cleared", d, 8'h02);
        do_read(8'h1C, d); chk("R6 hold A", d, 8'h11);
        do_read(8'h2C, d); chk("R6 causes empty", d, 8'h00);
        chk("R9 irq after causes clear", irq, 1);
        do_read(8'h0C, d); chk("R2 status A", d, 8'h04);
        chk("R9 status A drops irq", irq, 0);
    endtask

    task automatic t_tick();
        logic [7:0] d;
        do_write(8'h2C, 8'h01);
        pulse_tick();
        chk("R8 odd tick irq", irq, 0);
        do_read(8'h2C, d); chk("R8 odd tick cause", d, 8'h00);
        pulse_tick();
        chk("R8 second tick irq", irq, 1);
        do_read(8'h2C, d); chk("R8 both tx causes", d, 8'h11);
        do_read(8'h0C, d);
        do_write(8'h1C, 8'h41);
        chk("R7 tx A pulse", {tx_a_valid, tx_b_valid}, 2'b10);
        chk("R7 tx A data", tx_a_data, 8'h41);
        @(posedge clk); #1;
        chk("R7 tx A one cycle", tx_a_valid, 0);
        do_read(8'h2C, d); chk("R7 only A cleared", d, 8'h10);
        do_write(8'h5C, 8'h42);
        chk("R7 tx B pulse", {tx_a_valid, tx_b_valid}, 2'b01);
        chk("R7 tx B data", tx_b_data, 8'h42);
        do_read(8'h2C, d); chk("R7 B cleared", d, 8'h00);
        do_write(8'h2C, 8'h00);
        pulse_tick(); pulse_tick();
        do_read(8'h2C, d); chk("R8 masked ticks", d, 8'h00);
        chk("R8 masked irq", irq, 0);
        do_write(8'h2C, 8'h10);
        pulse_tick();
        do_read(8'h2C, d); chk("R8 count restarted", d, 8'h00);
        pulse_tick();
        do_read(8'h2C, d); chk("R8 fire via B enable", d, 8'h11);
        chk("R8 irq via B enable", irq, 1);
        do_read(8'h0C, d);
        chk("R9 cleared", irq, 0);
    endtask

    task automatic t_race();
        pulse_tick();
        @(negedge clk);
        tick = 1'b1; bus_rd = 1'b1; bus_addr = 8'h0C;
        @(posedge clk); #1;
        tick = 1'b0; bus_rd = 1'b0;
        chk("R9 set beats clear", irq, 1);
        chk("R2 status in race", bus_rdata, 8'h04);
        begin
            logic [7:0] d;
            do_read(8'h0C, d);
        end
        chk("R9 later clear", irq, 0);
    endtask

    task automatic t_cmd();
        do_write(8'h14, 8'h08);
        chk("R10 flush A", {flush_a, flush_b}, 2'b10);
        chk("R10 off A", tx_a_off, 1);
        @(posedge clk); #1;
        chk("R10 flush one cycle", flush_a, 0);
        chk("R10 off held", tx_a_off, 1);
        do_write(8'h14, 8'h04);
        chk("R10 on A", tx_a_off, 0);
        do_write(8'h54, 8'h08);
        chk("R10 off B", {tx_b_off, flush_b, tx_a_off}, 3'b110);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        do_write(8'h04, 8'hFF);
        do_write(8'h44, 8'hFF);
        do_write(8'h24, 8'hFF);
        do_read(8'h04, d); chk("R11 mode A reads 0", d, 8'h00);
        do_read(8'h44, d); chk("R11 mode B reads 0", d, 8'h00);
        do_read(8'h3C, d); chk("R11 unmapped reads 0", d, 8'h00);
        do_read(8'h2C, d); chk("R11 causes kept", d, 8'h11);
        push_rx(0, 8'h99);
        chk("R11 mask unchanged irq", irq, 0);
        do_read(8'h2C, d); chk("R11 mask unchanged cause", d, 8'h11);
        do_read(8'h1C, d); chk("R6 drain", d, 8'h99);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rx_masked();
        t_rx_enabled();
        t_tick();
        t_race();
        t_cmd();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule